// File: doc/BRIEF.md
# DAC Code and Load Register Controller

This block keeps the digital state of a single-channel converter: a staged code register, the latch whose value reaches the converter, and a default value that the output can be forced to. A serial receiver upstream hands it one decoded command at a time (opcode plus a 16-bit data word) while a frame-enable level marks the chip-select window. The block produces the effective code driven into the converter.

Two board-level pins act on the state beside the command path. An active-low load pin copies the staged code into the output latch for as long as it is held low. An auxiliary active-low pin is given one of two roles by command. In clear mode it wipes both the staged code and the latch back to the default value. In gate mode it forces the output to the default value without disturbing the latch, so the programmed value returns on release. A software gate bit gives the same hold from the command path. A frame during which a clear was seen drops every command except the role select until the frame closes.

Both pins pass through a two-stage synchronizer, so each acts two clock edges after it changes. A frame tracker with three states decides which commands are honoured. In `F_IDLE` no frame is open. It moves to `F_OPEN` when the frame opens with no clear active, or to `F_TAINT` if a clear is active at that moment. `F_OPEN` moves to `F_TAINT` when a clear becomes active. Both `F_OPEN` and `F_TAINT` return to `F_IDLE` when the frame closes.

Top module: `dac_code_ctrl`

## Requirements
- R1: While reset is asserted, the output code, staged code, latch and default value are all zero, the auxiliary role is none and the software gate is off.
- R2: A write-code command (opcode 0x1) while the load pin is high updates only the staged code. The output keeps its value.
- R3: A load command (opcode 0x2) copies the staged code into the latch. The output shows it on the next clock.
- R4: A write-and-load command (opcode 0x3) places its data in both the staged code and the latch at the same edge.
- R5: While the synchronized load pin is low, the latch follows the staged code. A write-code command then reaches the output on the next clock.
- R6: Code data is left-justified. The code is bits [15:16-DAC_W] of the data word, and the lower bits are ignored.
- R7: With auxiliary role clear (opcode 0x6, data[1:0]=01), a low synchronized auxiliary pin sets the staged code and the latch to the default value. It leaves the default value, role and software gate unchanged.
- R8: Once a clear is active inside a frame, opcodes 0x1 to 0x5 are dropped until the frame closes. Opcode 0x6 still executes. A clear that is active at a command's edge also drops it.
- R9: With auxiliary role gate (data[1:0]=10), a low synchronized auxiliary pin drives the default value to the output. Releasing it restores the latch value.
- R10: Opcode 0x5 sets the software gate to data[0]. While it is set, the output is the default value.
- R11: While the output is gated, write, default-write (opcode 0x4) and load commands still update the registers. Their effect appears once the gate is removed.
- R12: Opcodes outside 0x1 to 0x6 have no effect, and neither do commands presented while the frame-enable input is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| frame_en | input | 1 | High for the duration of a serial frame |
| cmd_valid | input | 1 | One-cycle strobe: a decoded command is presented |
| cmd_op | input | 4 | Command opcode |
| cmd_data | input | 16 | Command data word |
| ldac_n | input | 1 | Asynchronous active-low level load |
| aux_n | input | 1 | Asynchronous active-low auxiliary pin (clear or gate) |
| dac_code | output | DAC_W | Effective code to the converter |

## Verification
The hardest state to reach is a command that is dropped because a clear was seen earlier in the same frame, after the clear has already been released. To get there, the bench holds the frame open, pulses the auxiliary pin low long enough to pass the synchronizer, and raises it again. It then issues a default-value write, a role select and a write-and-load in that frame. The dropped default-value write cannot be seen directly, so the bench turns on the software gate later to expose the default value. It shows that the role select did execute by driving the auxiliary pin low and observing that no clear follows.

// File: rtl/dac_ctrl_pkg.sv
package dac_ctrl_pkg;

    localparam int WORD_W = 16;
    localparam int OP_W   = 4;

    typedef enum logic [OP_W-1:0] {
        OP_NOP      = 4'h0,
        OP_WR_CODE  = 4'h1,
        OP_LOAD     = 4'h2,
        OP_WR_LOAD  = 4'h3,
        OP_WR_RET   = 4'h4,
        OP_SW_GATE  = 4'h5,
        OP_AUX_MODE = 4'h6
    } op_e;

    typedef enum logic [1:0] {
        AUX_NONE  = 2'b00,
        AUX_CLEAR = 2'b01,
        AUX_GATE  = 2'b10,
        AUX_SPARE = 2'b11
    } aux_mode_e;

    typedef enum logic [1:0] {
        F_IDLE  = 2'b00,
        F_OPEN  = 2'b01,
        F_TAINT = 2'b10
    } frame_state_e;

endpackage

// File: rtl/dac_pin_sync.sv
module dac_pin_sync #(
    parameter int              W       = 1,
    parameter int              STAGES  = 2,
    parameter logic [W-1:0]    IDLE_V  = '1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] pin_in,
    output logic [W-1:0] pin_out
);

    logic [W-1:0] stage_q [STAGES];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage_q[0] <= IDLE_V;
        else        stage_q[0] <= pin_in;
    end

    for (genvar s = 1; s < STAGES; s++) begin : g_stage
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) stage_q[s] <= IDLE_V;
            else        stage_q[s] <= stage_q[s-1];
        end
    end

    assign pin_out = stage_q[STAGES-1];

endmodule

// File: rtl/dac_frame_fsm.sv
module dac_frame_fsm
    import dac_ctrl_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic frame_en,
    input  logic clr_active,
    output logic tainted,
    output logic blocked
);

    frame_state_e state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= F_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            F_IDLE: begin
                if (frame_en) state_d = clr_active ? F_TAINT : F_OPEN;
            end
            F_OPEN: begin
                if (!frame_en)       state_d = F_IDLE;
                else if (clr_active) state_d = F_TAINT;
            end
            F_TAINT: begin
                if (!frame_en) state_d = F_IDLE;
            end
            default: state_d = F_IDLE;
        endcase
    end

    always_comb begin
        tainted = (state_q == F_TAINT);
        blocked = tainted || clr_active;
    end

endmodule

// File: rtl/dac_reg_bank.sv
module dac_reg_bank
    import dac_ctrl_pkg::*;
#(
    parameter int DAC_W = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_fire,
    input  logic [OP_W-1:0]   cmd_op,
    input  logic [WORD_W-1:0] cmd_data,
    input  logic              blocked,
    input  logic              clr_active,
    input  logic              ldac_low,
    input  logic              aux_low,
    output logic [DAC_W-1:0]  code_q,
    output logic [DAC_W-1:0]  dac_q,
    output logic [DAC_W-1:0]  ret_q,
    output aux_mode_e         mode_q,
    output logic              sw_gate_q,
    output logic              gate_on,
    output logic [DAC_W-1:0]  dac_code
);

    localparam int MSB = WORD_W - 1;

    logic [DAC_W-1:0] field;
    logic [DAC_W-1:0] code_d, dac_d, ret_d;
    aux_mode_e        mode_d;
    logic             sw_gate_d;
    logic             cmd_ok;

    assign field  = cmd_data[MSB -: DAC_W];
    assign cmd_ok = cmd_fire && !blocked;

    always_comb begin
        code_d    = code_q;
        dac_d     = dac_q;
        ret_d     = ret_q;
        mode_d    = mode_q;
        sw_gate_d = sw_gate_q;
        if (cmd_fire && cmd_op == OP_AUX_MODE) begin
            mode_d = aux_mode_e'(cmd_data[1:0]);
        end
        if (clr_active) begin
            code_d = ret_q;
            dac_d  = ret_q;
        end else begin
            if (cmd_ok) begin
                unique case (cmd_op)
                    OP_WR_CODE: code_d = field;
                    OP_LOAD:    dac_d  = code_q;
                    OP_WR_LOAD: begin
                        code_d = field;
                        dac_d  = field;
                    end
                    OP_WR_RET:  ret_d     = field;
                    OP_SW_GATE: sw_gate_d = cmd_data[0];
                    default:    ;
                endcase
            end
            if (ldac_low) dac_d = code_d;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            code_q    <= '0;
            dac_q     <= '0;
            ret_q     <= '0;
            mode_q    <= AUX_NONE;
            sw_gate_q <= 1'b0;
        end else begin
            code_q    <= code_d;
            dac_q     <= dac_d;
            ret_q     <= ret_d;
            mode_q    <= mode_d;
            sw_gate_q <= sw_gate_d;
        end
    end

    always_comb begin
        gate_on  = sw_gate_q || (mode_q == AUX_GATE && aux_low);
        dac_code = gate_on ? ret_q : dac_q;
    end

endmodule

// File: rtl/dac_code_ctrl.sv
module dac_code_ctrl
    import dac_ctrl_pkg::*;
#(
    parameter int DAC_W     = 12,
    parameter int SYNC_DEPTH = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             frame_en,
    input  logic             cmd_valid,
    input  logic [3:0]       cmd_op,
    input  logic [15:0]      cmd_data,
    input  logic             ldac_n,
    input  logic             aux_n,
    output logic [DAC_W-1:0] dac_code
);

    logic [1:0]       pins_s;
    logic             ldac_low, aux_low;
    logic             clr_active, tainted, blocked, cmd_fire;
    logic [DAC_W-1:0] code_q, dac_q, ret_q;
    aux_mode_e        mode_q;
    logic             sw_gate_q, gate_on;

    dac_pin_sync #(
        .W      (2),
        .STAGES (SYNC_DEPTH),
        .IDLE_V (2'b11)
    ) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .pin_in  ({aux_n, ldac_n}),
        .pin_out (pins_s)
    );

    assign ldac_low   = !pins_s[0];
    assign aux_low    = !pins_s[1];
    assign clr_active = (mode_q == AUX_CLEAR) && aux_low;
    assign cmd_fire   = cmd_valid && frame_en;

    dac_frame_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .frame_en   (frame_en),
        .clr_active (clr_active),
        .tainted    (tainted),
        .blocked    (blocked)
    );

    dac_reg_bank #(
        .DAC_W (DAC_W)
    ) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .cmd_fire   (cmd_fire),
        .cmd_op     (cmd_op),
        .cmd_data   (cmd_data),
        .blocked    (blocked),
        .clr_active (clr_active),
        .ldac_low   (ldac_low),
        .aux_low    (aux_low),
        .code_q     (code_q),
        .dac_q      (dac_q),
        .ret_q      (ret_q),
        .mode_q     (mode_q),
        .sw_gate_q  (sw_gate_q),
        .gate_on    (gate_on),
        .dac_code   (dac_code)
    );

endmodule

// File: rtl/dac_code_ctrl_chk.sv
module dac_code_ctrl_chk #(
    parameter int DAC_W = 12
) (
    input logic             clk,
    input logic             rst_n,
    input logic             cmd_fire,
    input logic [3:0]       cmd_op,
    input logic             blocked,
    input logic             tainted,
    input logic             clr_active,
    input logic             ldac_low,
    input logic             gate_on,
    input logic [DAC_W-1:0] code_q,
    input logic [DAC_W-1:0] dac_q,
    input logic [DAC_W-1:0] ret_q,
    input logic [DAC_W-1:0] dac_code
);

    // R1: reset leaves a zero output
    a_r1_reset_zero: assert property (@(posedge clk)
        !rst_n |=> dac_code == '0);

    // R3: without a load source the latch holds
    a_r3_latch_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (!cmd_fire && !ldac_low && !clr_active) |=> $stable(dac_q));

    // R5: load pin low makes the latch track the staged code
    a_r5_level_load: assert property (@(posedge clk) disable iff (!rst_n)
        (ldac_low && !clr_active) |=> dac_q == code_q);

    // R7: clear returns staged code and latch to the default
    a_r7_clear_to_default: assert property (@(posedge clk) disable iff (!rst_n)
        clr_active |=> (code_q == ret_q && dac_q == ret_q));

    // R8: tainted frame drops gated commands
    a_r8_tainted_drop: assert property (@(posedge clk) disable iff (!rst_n)
        (tainted && cmd_fire && cmd_op != 4'h6 && !clr_active)
        |=> ($stable(code_q) && $stable(ret_q)));

    // R11: load still acts while the output is gated
    a_r11_load_under_gate: assert property (@(posedge clk) disable iff (!rst_n)
        (gate_on && cmd_fire && cmd_op == 4'h2 && !blocked)
        |=> dac_q == $past(code_q));

endmodule

bind dac_code_ctrl dac_code_ctrl_chk #(.DAC_W(DAC_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .cmd_fire   (cmd_fire),
    .cmd_op     (cmd_op),
    .blocked    (blocked),
    .tainted    (tainted),
    .clr_active (clr_active),
    .ldac_low   (ldac_low),
    .gate_on    (gate_on),
    .code_q     (code_q),
    .dac_q      (dac_q),
    .ret_q      (ret_q),
    .dac_code   (dac_code)
);

// File: tb/dac_code_ctrl_bench.sv
module dac_code_ctrl_bench;

    localparam int DW = 12;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          frame_en = 1'b0;
    logic          cmd_valid = 1'b0;
    logic [3:0]    cmd_op = 4'h0;
    logic [15:0]   cmd_data = 16'h0;
    logic          ldac_n = 1'b1;
    logic          aux_n = 1'b1;
    logic [DW-1:0] dac_code;

    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    dac_code_ctrl #(.DAC_W(DW)) u_dac_code_ctrl (
        .clk(clk), .rst_n(rst_n), .frame_en(frame_en), .cmd_valid(cmd_valid),
        .cmd_op(cmd_op), .cmd_data(cmd_data), .ldac_n(ldac_n), .aux_n(aux_n),
        .dac_code(dac_code)
    );

    // behavioural reference model
    int  m_code, m_dac, m_ret, m_mode, m_sw, m_taint;
    bit  l_h[$];
    bit  a_h[$];

    task automatic model_reset();
        m_code = 0; m_dac = 0; m_ret = 0; m_mode = 0; m_sw = 0; m_taint = 0;
        l_h = '{1'b1, 1'b1};
        a_h = '{1'b1, 1'b1};
    endtask

    initial model_reset();

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            model_reset();
        end else begin
            int  fld, nc, nd, nr, nm, ns;
            bit  clr, blk, fire, lo;
            lo   = !l_h[1];
            clr  = (m_mode == 1) && !a_h[1];
            blk  = (m_taint != 0) || clr;
            fire = cmd_valid && frame_en;
            fld  = int'(cmd_data) / (1 << (16 - DW));
            nc = m_code; nd = m_dac; nr = m_ret; nm = m_mode; ns = m_sw;
            if (fire && cmd_op == 4'h6) nm = int'(cmd_data) % 4;
            if (clr) begin
                nc = m_ret; nd = m_ret;
            end else begin
                if (fire && !blk) begin
                    if (cmd_op == 4'h1) nc = fld;
                    if (cmd_op == 4'h2) nd = m_code;
                    if (cmd_op == 4'h3) begin nc = fld; nd = fld; end
                    if (cmd_op == 4'h4) nr = fld;
                    if (cmd_op == 4'h5) ns = int'(cmd_data) % 2;
                end
                if (lo) nd = nc;
            end
            m_taint = (frame_en && (m_taint != 0 || clr)) ? 1 : 0;
            m_code = nc; m_dac = nd; m_ret = nr; m_mode = nm; m_sw = ns;
            void'(l_h.pop_back()); l_h.push_front(ldac_n);
            void'(a_h.pop_back()); a_h.push_front(aux_n);
        end
    end

    function automatic int model_out();
        bit g;
        g = (m_sw != 0) || (m_mode == 2 && !a_h[1]);
        return g ? m_ret : m_dac;
    endfunction

    always @(negedge clk) begin
        if (rst_n) begin
            checks++;
            if (int'(dac_code) != model_out()) begin
                errors++;
                $display("FAIL model R2 R3 R4 R5 R7 R9 R10: actual %h expected %h at %0t",
                         dac_code, model_out(), $time);
            end
        end
    end

    task automatic check(input string req, input int exp);
        checks++;
        if (int'(dac_code) != exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, dac_code, exp);
        end
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic cmd_in_frame(input logic [3:0] op, input logic [15:0] d);
        cmd_valid = 1'b1; cmd_op = op; cmd_data = d;
        cyc(1);
        cmd_valid = 1'b0;
    endtask

    task automatic send(input logic [3:0] op, input logic [15:0] d);
        frame_en = 1'b1;
        cmd_in_frame(op, d);
        frame_en = 1'b0;
        cyc(1);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        cyc(3);
        check("R1 reset", 0);
        rst_n = 1'b1;
        cyc(2);
        send(4'h1, 16'hABC0); check("R2 write no load", 0);
        send(4'h2, 16'h0000); check("R3 load", 12'hABC);
        send(4'h3, 16'h1230); check("R4 write and load", 12'h123);
        send(4'h3, 16'h456F); check("R6 left justified", 12'h456);
        ldac_n = 1'b0; cyc(3);
        send(4'h1, 16'h7770); check("R5 level load", 12'h777);
        ldac_n = 1'b1; cyc(3);
        send(4'h7, 16'hFFF0); send(4'h0, 16'hEEE0); check("R12 bad opcode", 12'h777);
        cmd_valid = 1'b1; cmd_op = 4'h3; cmd_data = 16'hDDD0; cyc(1); cmd_valid = 1'b0; cyc(1);
        check("R12 outside frame", 12'h777);
        send(4'h4, 16'h5550); check("R11 default write hidden", 12'h777);
        send(4'h5, 16'h0001); check("R10 sw gate on", 12'h555);
        send(4'h1, 16'h1110); send(4'h2, 16'h0000); check("R11 load under gate", 12'h555);
        send(4'h5, 16'h0000); check("R10 sw gate off", 12'h111);
        send(4'h6, 16'h0002); aux_n = 1'b0; cyc(3); check("R9 pin gate", 12'h555);
        send(4'h3, 16'h2220); check("R11 write under pin gate", 12'h555);
        aux_n = 1'b1; cyc(3); check("R9 gate release", 12'h222);
        send(4'h6, 16'h0001); aux_n = 1'b0; cyc(3); check("R7 clear", 12'h555);
        aux_n = 1'b1; cyc(3);
        send(4'h2, 16'h0000); check("R7 staged code cleared", 12'h555);
        send(4'h4, 16'h3330); send(4'h3, 16'h6660);
        aux_n = 1'b0; cyc(3); aux_n = 1'b1; cyc(3);
        send(4'h5, 16'h0001); check("R7 default kept", 12'h333);
        send(4'h5, 16'h0000); check("R7 latch cleared", 12'h333);
        // tainted frame
        frame_en = 1'b1; cyc(1);
        aux_n = 1'b0; cyc(3); aux_n = 1'b1; cyc(3);
        cmd_in_frame(4'h4, 16'h9990);
        cmd_in_frame(4'h6, 16'h0000);
        cmd_in_frame(4'h3, 16'h8880);
        frame_en = 1'b0; cyc(1);
        check("R8 write-load dropped", 12'h333);
        aux_n = 1'b0; cyc(3); check("R8 mode select ran", 12'h333);
        send(4'h3, 16'h8880); check("R8 gating ends with frame", 12'h888);
        aux_n = 1'b1; cyc(3);
        send(4'h5, 16'h0001); check("R8 default write dropped", 12'h333);
        send(4'h5, 16'h0000);
        rst_n = 1'b0; cyc(1); check("R1 reset mid run", 0);
        cyc(1); rst_n = 1'b1; cyc(2);
        aux_n = 1'b0; cyc(3); check("R1 role none after reset", 0);
        aux_n = 1'b1; cyc(3);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule